// File: doc/BRIEF.md
# Scrolling Warning Text Display

This block drives a four-digit, time-multiplexed seven-segment display with a warning word. The word is fed in one character at a time. Each character enters at the rightmost digit and moves one digit to the left at each step. Only the three rightmost digits are used; the leftmost digit is never lit.

The word is d, A, n, G, E, r. A configurable number of dot-only positions follows it. Then the pass starts again. A surrounding controller raises the enable when the tank reaches its full level and holds it high while the tank drains. It raises the blank request once every level indicator has gone dark.

Each rise of the enable restarts the text at its first letter. The step period is about 0.67 s. Each digit is refreshed at about 1 kHz.

Top module: `warn_scroll_display`

## Requirements
- R1: The leftmost anode line (`anode_n[3]`) is never driven low.
- R2: At most one anode line is low at any time. Over any window of NUM_DIGITS×SCAN_CYCLES clocks, each of the three right digits is selected exactly once. `anode_n[0]` is the rightmost digit.
- R3: On the clock edge that samples `scroll_en` high after it was low, the rightmost digit loads the letter d. The other two active digits load blank.
- R4: While enabled, every STEP_CYCLES clocks the text shifts one digit to the left. The next message character then enters the rightmost digit.
- R5: The character order is d, A, n, G, E, r, then PAD_DOTS dot-only positions (default 2), repeating without end.
- R6: Segment lines are active low, with bit 0 = a through bit 6 = g. The decimal point is a separate active-low line. The glyphs are:

  | Glyph | Lit segments |
  |-------|--------------|
  | d | b, c, d, e, g |
  | A | a, b, c, e, f, g |
  | n | c, e, g |
  | G | a, c, d, e, f |
  | E | a, d, e, f, g |
  | r | e, g |
  | dot | decimal point only |
  | blank | none |

- R7: While `blank_req` is high, all anode lines are high. Scrolling continues underneath, so the text is at the position elapsed time dictates when the request drops.
- R8: While `scroll_en` is low, all anode lines are high.
- R9: During reset with `scroll_en` low, all anode, segment and decimal-point lines are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scroll_en | input | 1 | Scroll enable; a rising edge restarts the text |
| blank_req | input | 1 | Forces all digits dark |
| seg_n | output | 7 | Segment lines a..g, active low, a in bit 0 |
| dp_n | output | 1 | Decimal point, active low |
| anode_n | output | 4 | Digit selects, active low, bit 0 rightmost |

## Verification
The hardest condition to reach from the ports is a blanked display whose hidden scroll position keeps advancing. Proving this takes the lit text from a step that was never shown. The stimulus table therefore marks two consecutive steps as blanked in the middle of a long run. The step that follows must show the characters for its elapsed time, not the ones last seen. The per-digit contents are visible only one digit at a time. So each check gathers a full refresh frame in the middle of a step period before comparing all three digits together.

// File: rtl/warn_disp_pkg.sv
package warn_disp_pkg;

   typedef logic [2:0] char_t;

   localparam char_t CH_BLANK = 3'd0;
   localparam char_t CH_D     = 3'd1;
   localparam char_t CH_A     = 3'd2;
   localparam char_t CH_N     = 3'd3;
   localparam char_t CH_G     = 3'd4;
   localparam char_t CH_E     = 3'd5;
   localparam char_t CH_R     = 3'd6;
   localparam char_t CH_DOT   = 3'd7;

   localparam int unsigned WORD_LEN = 6;

   // Active-high glyph: bit 7 = decimal point, bits 6..0 = g..a
   function automatic logic [7:0] glyph(input char_t c);
      logic [7:0] p;
      case (c)
         CH_D:    p = 8'h5E;
         CH_A:    p = 8'h77;
         CH_N:    p = 8'h54;
         CH_G:    p = 8'h3D;
         CH_E:    p = 8'h79;
         CH_R:    p = 8'h50;
         CH_DOT:  p = 8'h80;
         default: p = 8'h00;
      endcase
      return p;
   endfunction

   // Message character at a position; positions past the word are dots
   function automatic char_t msg_char(input int unsigned pos);
      char_t c;
      case (pos)
         0:       c = CH_D;
         1:       c = CH_A;
         2:       c = CH_N;
         3:       c = CH_G;
         4:       c = CH_E;
         5:       c = CH_R;
         default: c = CH_DOT;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/warn_step_timer.sv
module warn_step_timer #(
   parameter int unsigned STEP_CYCLES = 33_500_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic restart_i,
   output logic step_o
);
   localparam int unsigned CW = (STEP_CYCLES > 2) ? $clog2(STEP_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);

   generate
      if (STEP_CYCLES < 2) begin : g_bad_step
         $error("STEP_CYCLES must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart_i) begin
         cnt_q <= '0;
      end else if (run_i) begin
         if (cnt_q == LAST) cnt_q <= '0;
         else               cnt_q <= cnt_q + 1'b1;
      end
   end

   assign step_o = run_i && !restart_i && (cnt_q == LAST);

   // R4
   step_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // R4
   step_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_o) |=> (cnt_q == '0));

endmodule

// File: rtl/warn_scroll_shift.sv
module warn_scroll_shift
   import warn_disp_pkg::*;
#(
   parameter int unsigned ACTIVE_DIGITS = 3,
   parameter int unsigned PAD_DOTS      = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           en_i,
   input  logic                           step_i,
   output logic                           rise_o,
   output logic [ACTIVE_DIGITS-1:0][2:0]  win_o
);
   localparam int unsigned MSG_LEN = WORD_LEN + PAD_DOTS;
   localparam int unsigned IW      = $clog2(MSG_LEN);
   localparam logic [IW-1:0] IDX_LAST = IW'(MSG_LEN - 1);

   generate
      if (ACTIVE_DIGITS < 1) begin : g_bad_act
         $error("ACTIVE_DIGITS must be at least 1");
      end
   endgenerate

   logic                          en_q;
   logic [IW-1:0]                 idx_q;
   logic [ACTIVE_DIGITS-1:0][2:0] win_q;
   char_t                         next_ch;

   assign rise_o  = en_i && !en_q;
   assign next_ch = msg_char(int'(idx_q));

   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= en_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (rise_o) begin
         idx_q <= IW'(1);
      end else if (en_i && step_i) begin
         if (idx_q == IDX_LAST) idx_q <= '0;
         else                   idx_q <= idx_q + 1'b1;
      end
   end

   generate
      if (ACTIVE_DIGITS == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n)                win_q <= '0;
            else if (rise_o)           win_q <= CH_D;
            else if (en_i && step_i)   win_q <= next_ch;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (!rst_n)                win_q <= '0;
            else if (rise_o)           win_q <= {{(ACTIVE_DIGITS-1){CH_BLANK}}, CH_D};
            else if (en_i && step_i)   win_q <= {win_q[ACTIVE_DIGITS-2:0], next_ch};
         end

         // R4
         shift_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en_i && step_i && !rise_o) |=> (win_q[1] == $past(win_q[0])));
      end
   endgenerate

   assign win_o = win_q;

   // R3
   rise_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> (win_q[0] == CH_D && idx_q == IW'(1)));

   // R5
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= IDX_LAST);

endmodule

// File: rtl/warn_digit_scan.sv
module warn_digit_scan
   import warn_disp_pkg::*;
#(
   parameter int unsigned NUM_DIGITS    = 4,
   parameter int unsigned ACTIVE_DIGITS = 3,
   parameter int unsigned SCAN_CYCLES   = 12_500
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           lit_i,
   input  logic [ACTIVE_DIGITS-1:0][2:0]  win_i,
   output logic [6:0]                     seg_n_o,
   output logic                           dp_n_o,
   output logic [NUM_DIGITS-1:0]          anode_n_o
);
   localparam int unsigned SW = $clog2(NUM_DIGITS);
   localparam int unsigned DW = (SCAN_CYCLES > 2) ? $clog2(SCAN_CYCLES) : 1;
   localparam logic [DW-1:0] DIV_LAST = DW'(SCAN_CYCLES - 1);
   localparam logic [SW-1:0] SEL_LAST = SW'(NUM_DIGITS - 1);

   generate
      if (NUM_DIGITS < 2) begin : g_bad_num
         $error("NUM_DIGITS must be at least 2");
      end
      if (ACTIVE_DIGITS > NUM_DIGITS) begin : g_bad_act
         $error("ACTIVE_DIGITS cannot exceed NUM_DIGITS");
      end
      if (SCAN_CYCLES < 2) begin : g_bad_scan
         $error("SCAN_CYCLES must be at least 2");
      end
   endgenerate

   logic [DW-1:0] div_q;
   logic [SW-1:0] sel_q;
   logic [7:0]    pat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q <= '0;
         sel_q <= '0;
      end else if (div_q == DIV_LAST) begin
         div_q <= '0;
         sel_q <= (sel_q == SEL_LAST) ? '0 : sel_q + 1'b1;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   genvar d;
   generate
      for (d = 0; d < NUM_DIGITS; d++) begin : g_anode
         if (d < ACTIVE_DIGITS) begin : g_on
            assign anode_n_o[d] = !(lit_i && sel_q == SW'(d));
         end else begin : g_off
            assign anode_n_o[d] = 1'b1;
         end
      end
   endgenerate

   always_comb begin
      pat = 8'h00;
      if (lit_i) begin
         for (int i = 0; i < ACTIVE_DIGITS; i++) begin
            if (sel_q == SW'(i)) pat = glyph(win_i[i]);
         end
      end
   end

   assign seg_n_o = ~pat[6:0];
   assign dp_n_o  = ~pat[7];

   // R2
   one_anode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~anode_n_o));

   // R1
   msb_anode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      anode_n_o[NUM_DIGITS-1]);

   // R2
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (div_q != DIV_LAST) |=> $stable(sel_q));

endmodule

// File: rtl/warn_scroll_display.sv
module warn_scroll_display #(
   parameter int unsigned CLK_HZ        = 50_000_000,
   parameter int unsigned REFRESH_HZ    = 1_000,
   parameter int unsigned STEP_MS       = 670,
   parameter int unsigned NUM_DIGITS    = 4,
   parameter int unsigned ACTIVE_DIGITS = 3,
   parameter int unsigned PAD_DOTS      = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scroll_en,
   input  logic                  blank_req,
   output logic [6:0]            seg_n,
   output logic                  dp_n,
   output logic [NUM_DIGITS-1:0] anode_n
);
   localparam int unsigned STEP_CYCLES = (CLK_HZ / 1000) * STEP_MS;
   localparam int unsigned SCAN_CYCLES = CLK_HZ / (REFRESH_HZ * NUM_DIGITS);

   logic                          step;
   logic                          rise;
   logic                          lit;
   logic [ACTIVE_DIGITS-1:0][2:0] win;

   assign lit = scroll_en && !blank_req;

   warn_step_timer #(
      .STEP_CYCLES (STEP_CYCLES)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (scroll_en),
      .restart_i (rise),
      .step_o    (step)
   );

   warn_scroll_shift #(
      .ACTIVE_DIGITS (ACTIVE_DIGITS),
      .PAD_DOTS      (PAD_DOTS)
   ) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (scroll_en),
      .step_i (step),
      .rise_o (rise),
      .win_o  (win)
   );

   warn_digit_scan #(
      .NUM_DIGITS    (NUM_DIGITS),
      .ACTIVE_DIGITS (ACTIVE_DIGITS),
      .SCAN_CYCLES   (SCAN_CYCLES)
   ) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .lit_i     (lit),
      .win_i     (win),
      .seg_n_o   (seg_n),
      .dp_n_o    (dp_n),
      .anode_n_o (anode_n)
   );

   // R7
   blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blank_req |-> (&anode_n));

   // R8
   idle_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !scroll_en |-> (&anode_n));

endmodule

// File: tb/warn_scroll_display_bench.sv
module warn_scroll_display_bench;

   localparam int unsigned CLK_HZ  = 8000;
   localparam int unsigned REF_HZ  = 1000;
   localparam int unsigned STEP_MS = 8;
   localparam int unsigned NDIG    = 4;
   localparam int unsigned STEP    = (CLK_HZ / 1000) * STEP_MS;   // 64
   localparam int unsigned FRAME   = NDIG * (CLK_HZ / (REF_HZ * NDIG)); // 8

   // Active-high glyphs {dp,g..a}
   localparam logic [7:0] BL = 8'h00, GD = 8'h5E, GA = 8'h77, GN = 8'h54;
   localparam logic [7:0] GG = 8'h3D, GE = 8'h79, GR = 8'h50, DT = 8'h80;

   // {blank_req, digit2, digit1, digit0} per step after a restart
   localparam logic [24:0] TBL [16] = '{
      {1'b0, BL, BL, GD}, {1'b0, BL, GD, GA}, {1'b0, GD, GA, GN}, {1'b0, GA, GN, GG},
      {1'b0, GN, GG, GE}, {1'b0, GG, GE, GR}, {1'b0, GE, GR, DT}, {1'b0, GR, DT, DT},
      {1'b0, DT, DT, GD}, {1'b0, DT, GD, GA}, {1'b0, GD, GA, GN}, {1'b1, GA, GN, GG},
      {1'b1, GN, GG, GE}, {1'b0, GG, GE, GR}, {1'b0, GE, GR, DT}, {1'b0, GR, DT, DT}
   };

   logic            clk = 1'b0;
   logic            rst_n;
   logic            scroll_en;
   logic            blank_req;
   logic [6:0]      seg_n;
   logic            dp_n;
   logic [NDIG-1:0] anode_n;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   warn_scroll_display #(
      .CLK_HZ     (CLK_HZ),
      .REFRESH_HZ (REF_HZ),
      .STEP_MS    (STEP_MS)
   ) u_warn_scroll_display (
      .clk       (clk),
      .rst_n     (rst_n),
      .scroll_en (scroll_en),
      .blank_req (blank_req),
      .seg_n     (seg_n),
      .dp_n      (dp_n),
      .anode_n   (anode_n)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Sample one refresh frame at falling edges
   task automatic capture(output logic [23:0] got, output logic [2:0] seen,
                          output bit bad);
      logic [NDIG-1:0] an;
      got = '0; seen = '0; bad = 1'b0;
      for (int s = 0; s < FRAME; s++) begin
         @(negedge clk);
         an = ~anode_n;
         if ($countones(an) > 1 || an[NDIG-1]) bad = 1'b1;
         for (int d = 0; d < 3; d++) begin
            if (an[d]) begin
               got[d*8 +: 8] = ~{dp_n, seg_n};
               seen[d] = 1'b1;
            end
         end
      end
   endtask

   // One step period, starting at the falling edge where the step begins
   task automatic run_step(input int k);
      logic [23:0] got;
      logic [2:0]  seen;
      bit          bad;
      blank_req = TBL[k][24];
      repeat (2) @(negedge clk);
      capture(got, seen, bad);
      // R1 R2: leftmost dark, single select
      check(!bad, "R1/R2 anode select", 32'(bad), 32'd0);
      if (TBL[k][24]) begin
         // R7: blanked while scroll runs on
         check(seen == 3'b000, "R7 blank", 32'(seen), 32'd0);
      end else begin
         // R2 R4 R5 R6: every digit once, shifted text, glyph encoding
         check(seen == 3'b111, "R2 frame coverage", 32'(seen), 32'h7);
         check(got == TBL[k][23:0], $sformatf("R4/R5/R6 step %0d", k),
               32'(got), 32'(TBL[k][23:0]));
      end
      repeat (STEP - 2 - FRAME) @(negedge clk);
   endtask

   initial begin
      repeat (100_000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [23:0] got;
      logic [2:0]  seen;
      bit          bad;
      rst_n = 1'b0; scroll_en = 1'b0; blank_req = 1'b0;
      repeat (2) @(negedge clk);
      capture(got, seen, bad);
      // R9: reset state all dark
      check(seen == 3'b000 && !bad, "R9 anodes in reset", 32'(anode_n), 32'hF);
      check(seg_n == 7'h7F && dp_n, "R9 segments in reset", 32'({dp_n, seg_n}), 32'hFF);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      capture(got, seen, bad);
      // R8: enable low keeps display dark after reset
      check(seen == 3'b000 && !bad, "R8 idle dark", 32'(seen), 32'd0);

      // R3 R4 R5 R7: table walk from the first rise of enable
      scroll_en = 1'b1;
      for (int k = 0; k < 16; k++) run_step(k);

      // R8: drop enable mid-run
      scroll_en = 1'b0;
      blank_req = 1'b0;
      repeat (2) @(negedge clk);
      capture(got, seen, bad);
      check(seen == 3'b000 && !bad, "R8 enable low", 32'(seen), 32'd0);
      repeat (5) @(negedge clk);

      // R3: a new rise restarts at the first letter, timer restarted too
      scroll_en = 1'b1;
      run_step(0);
      run_step(1);
      run_step(2);

      // R3: one-cycle glitch low mid-step restarts again
      repeat (20) @(negedge clk);
      scroll_en = 1'b0;
      @(negedge clk);
      scroll_en = 1'b1;
      run_step(0);
      run_step(1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule